// File: doc/BRIEF.md
# Misaligned Memory Access Handler

This block sits between a load/store unit and a data memory whose port is one 64-bit word wide. It accepts byte, halfword, word and doubleword requests, detects misalignment from the low address bits and the access size, and produces the word address, byte enables and lane-shifted write data for the memory. For loads, it gathers the returned lanes into a zero-extended, right-justified result.

A static policy input selects what happens to a misaligned request. In trap policy, the request is consumed but never reaches memory. Instead, a fault carrying the offending byte address is raised and held until the trap logic acknowledges it. In split policy, a request that straddles two memory words is served by two aligned accesses on consecutive cycles, and the two halves are merged little-endian. A misaligned request that stays inside one memory word needs only lane steering and is served in one access.

Aligned requests use exactly one memory access under both policies and add no cycles. The memory is assumed to accept one access per cycle and to return read data on the cycle after the access.

Top module: `mem_align_unit`

## Requirements
- R1: An aligned request (byte address a multiple of the access size; size code 0 = byte, 1 = halfword, 2 = word, 3 = doubleword) is accepted while `reqReady` is high. It drives exactly one memory access in its acceptance cycle, and `rspValid` pulses on the following cycle, under either policy.
- R2: A load returns the addressed bytes little-endian (lowest address in bits 7:0), zero-extended to 64 bits.
- R3: A store sets `memBe` bit i exactly for the lanes i (byte address modulo 8) it writes, carries the store bytes in those lanes of `memWdata`, and leaves all other memory bytes unchanged.
- R4: With `splitMode` low (trap policy), a misaligned request causes no memory access and no response. `faultValid` rises on the cycle after acceptance, and `faultAddr` equals the request address.
- R5: While `faultValid` is high, `reqReady` is low and no memory access occurs. The fault and its address hold until a cycle with `faultAck` high; on the next cycle `faultValid` is low and `reqReady` is high.
- R6: With `splitMode` high, a request whose bytes span two memory words makes two accesses on consecutive cycles: first the word holding the request address, then the next word. `reqReady` is low during the second access, and `rspValid` pulses two cycles after acceptance.
- R7: A split load takes its lower-addressed bytes from the first access and its higher-addressed bytes from the second, and returns them merged as in R2.
- R8: A split store enables, in the first access, only lanes from the address offset up to lane 7. In the second access it enables only lanes 0 up to the last byte of the request.
- R9: With `splitMode` high, a misaligned request contained in one memory word makes one access, responds on the next cycle, and raises no fault.
- R10: Byte requests at any offset never fault under trap policy.
- R11: After reset, `reqReady` is high and `memValid`, `rspValid` and `faultValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| splitMode | input | 1 | Policy: 0 traps misaligned requests, 1 splits them |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Handler can take a request this cycle |
| reqWrite | input | 1 | 1 store, 0 load |
| reqSize | input | 2 | Access size code (0 byte .. 3 doubleword) |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Store data, right-justified |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Load result, zero-extended (0 for stores) |
| faultValid | output | 1 | Misalignment fault pending |
| faultAddr | output | ADDR_W | Address of the faulting request |
| faultAck | input | 1 | Clears a pending fault |
| memValid | output | 1 | Memory access this cycle |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memBe | output | DATA_W/8 | Byte lane enables |
| memWdata | output | DATA_W | Lane-aligned write data |
| memRdata | input | DATA_W | Read data, valid the cycle after a read access |

## Verification
A bad control state is visible at the ports within one or two cycles. A lost split step leaves the second word unread, which shows up as wrong high bytes in `rspRdata` or as a response one cycle early. A stuck fault state shows as `reqReady` staying low after the acknowledge. A datapath error in the held offset or size shows as wrong lanes in the second access's `memBe`, or as load data shifted by whole bytes. A wrong merge is checked by reading back stored data through later loads.

// File: rtl/mem_align_pkg.sv
package mem_align_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SECOND = 2'd1,
    ST_FAULT  = 2'd2
  } alignStateE;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;       // latch accepted request
    logic issueSecond;  // drive the upper-word access from held request
    logic grabLow;      // store first returned word
    logic mergeTwo;     // response combines two words
  } alignStrobeT;

endpackage

// File: rtl/mem_align_ctrl.sv
module mem_align_ctrl
  import mem_align_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        splitMode,
  input  logic        reqValid,
  input  logic        misaligned,
  input  logic        crosses,
  input  logic        faultAck,
  output logic        reqReady,
  output logic        memValid,
  output logic        rspValid,
  output logic        faultValid,
  output alignStrobeT strobe
);

  alignStateE stateQ, stateD;
  logic rspQ, mergeQ;
  logic accept, trapIt, splitIt, finalAccess;

  assign reqReady    = (stateQ == ST_IDLE);
  assign accept      = reqValid && reqReady;
  assign trapIt      = accept && misaligned && !splitMode;
  assign splitIt     = accept && splitMode && crosses;
  assign memValid    = (accept && !trapIt) || (stateQ == ST_SECOND);
  assign finalAccess = (accept && !trapIt && !splitIt) || (stateQ == ST_SECOND);
  assign faultValid  = (stateQ == ST_FAULT);
  assign rspValid    = rspQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (trapIt)       stateD = ST_FAULT;
        else if (splitIt) stateD = ST_SECOND;
      end
      ST_SECOND: stateD = ST_IDLE;
      ST_FAULT:  if (faultAck) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      rspQ   <= 1'b0;
      mergeQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      rspQ   <= finalAccess;
      mergeQ <= (stateQ == ST_SECOND);
    end
  end

  always_comb begin
    strobe.capReq      = accept;
    strobe.issueSecond = (stateQ == ST_SECOND);
    strobe.grabLow     = (stateQ == ST_SECOND);
    strobe.mergeTwo    = mergeQ;
  end

  // R5: a pending fault blocks both new requests and memory traffic
  assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (!reqReady && !memValid));

  // R5: acknowledge releases the fault on the next cycle
  assert_fault_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultAck) |=> (!faultValid && reqReady));

  // R1: every response follows a memory access one cycle earlier
  assert_rsp_after_access_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(memValid));

  // R6: the second access directly follows an accepted split request
  assert_second_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueSecond |-> ($past(reqValid && reqReady) && !reqReady));

endmodule

// File: rtl/mem_align_datapath.sv
module mem_align_datapath
  import mem_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  alignStrobeT       strobe,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              misaligned,
  output logic              crosses,
  output logic [ADDR_W-1:0] heldAddr,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W/8-1:0] memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int WORD_W = ADDR_W - OFF_W;
  localparam int CNT_W  = OFF_W + 1;

  // Two-word lane span: 'bytes' ones starting at lane 'off'
  function automatic logic [2*LANES-1:0] laneSpan(input logic [CNT_W-1:0] bytes,
                                                   input logic [OFF_W-1:0] off);
    logic [2*LANES-1:0] ones;
    ones = ({{(2*LANES-1){1'b0}}, 1'b1} << bytes) - 1'b1;
    return ones << off;
  endfunction

  function automatic logic [2*DATA_W-1:0] placeData(input logic [DATA_W-1:0] data,
                                                     input logic [OFF_W-1:0] off);
    return {{DATA_W{1'b0}}, data} << {off, 3'b000};
  endfunction

  // Live request decode
  logic [OFF_W-1:0]   liveOff;
  logic [CNT_W-1:0]   liveBytes;
  logic [CNT_W-1:0]   liveLowMask;
  logic [2*LANES-1:0] liveSpan;
  logic [2*DATA_W-1:0] livePlaced;

  assign liveOff     = reqAddr[OFF_W-1:0];
  assign liveBytes   = CNT_W'(1) << reqSize;
  assign liveLowMask = liveBytes - 1'b1;
  assign misaligned  = (liveOff & liveLowMask[OFF_W-1:0]) != '0;
  assign crosses     = ({1'b0, liveOff} + liveBytes) > CNT_W'(LANES);
  assign liveSpan    = laneSpan(liveBytes, liveOff);
  assign livePlaced  = placeData(reqWdata, liveOff);

  // Held request
  logic [ADDR_W-1:0] hAddrQ;
  logic [1:0]        hSizeQ;
  logic              hWriteQ;
  logic [DATA_W-1:0] hWdataQ;
  logic [DATA_W-1:0] lowBufQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hAddrQ  <= '0;
      hSizeQ  <= '0;
      hWriteQ <= 1'b0;
      hWdataQ <= '0;
      lowBufQ <= '0;
    end else begin
      if (strobe.capReq) begin
        hAddrQ  <= reqAddr;
        hSizeQ  <= reqSize;
        hWriteQ <= reqWrite;
        hWdataQ <= reqWdata;
      end
      if (strobe.grabLow) lowBufQ <= memRdata;
    end
  end

  assign heldAddr = hAddrQ;

  logic [OFF_W-1:0]    hOff;
  logic [CNT_W-1:0]    hBytes;
  logic [2*LANES-1:0]  hSpan;
  logic [2*DATA_W-1:0] hPlaced;
  logic [WORD_W-1:0]   hNextWord;

  assign hOff      = hAddrQ[OFF_W-1:0];
  assign hBytes    = CNT_W'(1) << hSizeQ;
  assign hSpan     = laneSpan(hBytes, hOff);
  assign hPlaced   = placeData(hWdataQ, hOff);
  assign hNextWord = hAddrQ[ADDR_W-1:OFF_W] + 1'b1;

  // Memory side: lower word from live request, upper word from held one
  always_comb begin
    if (strobe.issueSecond) begin
      memWrite = hWriteQ;
      memAddr  = {hNextWord, {OFF_W{1'b0}}};
      memBe    = hSpan[2*LANES-1:LANES];
      memWdata = hPlaced[2*DATA_W-1:DATA_W];
    end else begin
      memWrite = reqWrite;
      memAddr  = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      memBe    = liveSpan[LANES-1:0];
      memWdata = livePlaced[DATA_W-1:0];
    end
  end

  // Load merge: concatenate, shift down by offset, keep size lanes
  logic [2*DATA_W-1:0] pairWords;
  logic [2*DATA_W-1:0] pairShifted;

  assign pairWords   = strobe.mergeTwo ? {memRdata, lowBufQ} : {{DATA_W{1'b0}}, memRdata};
  assign pairShifted = pairWords >> {hOff, 3'b000};

  for (genvar laneIdx = 0; laneIdx < LANES; laneIdx++) begin : g_rspLane
    assign rspRdata[8*laneIdx +: 8] =
      ((CNT_W'(laneIdx) < hBytes) && !hWriteQ) ? pairShifted[8*laneIdx +: 8] : 8'h00;
  end

  // R8: the upper-word access only enables lanes from lane 0 upward without gaps
  assert_second_low_lanes_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueSecond |-> (memBe[0] && ((memBe & (memBe + 1'b1)) == '0)));

endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
  import mem_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                splitMode,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [1:0]          reqSize,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                faultValid,
  output logic [ADDR_W-1:0]   faultAddr,
  input  logic                faultAck,
  output logic                memValid,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memBe,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata
);

  localparam int LANES = DATA_W / 8;

  alignStrobeT strobe;
  logic misaligned, crosses;

  mem_align_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .splitMode  (splitMode),
    .reqValid   (reqValid),
    .misaligned (misaligned),
    .crosses    (crosses),
    .faultAck   (faultAck),
    .reqReady   (reqReady),
    .memValid   (memValid),
    .rspValid   (rspValid),
    .faultValid (faultValid),
    .strobe     (strobe)
  );

  mem_align_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .misaligned (misaligned),
    .crosses    (crosses),
    .heldAddr   (faultAddr),
    .memWrite   (memWrite),
    .memAddr    (memAddr),
    .memBe      (memBe),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .rspRdata   (rspRdata)
  );

  // R6: second access targets the word after the first
  assert_second_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueSecond |-> (memAddr == $past(memAddr) + ADDR_W'(LANES)));

  // R3: every memory access enables at least one lane
  assert_be_present_R3: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memBe != '0));

  // R5: fault address is stable while the fault is pending
  assert_fault_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && $past(faultValid)) |-> $stable(faultAddr));

  // R9: faults only arise under the trap policy
  assert_no_fault_split_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultValid) |-> !splitMode);

endmodule

// File: tb/mem_align_unit_tb.sv
module mem_align_unit_tb;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic splitMode = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [1:0] reqSize = 2'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic rspValid;
  logic [DATA_W-1:0] rspRdata;
  logic faultValid;
  logic [ADDR_W-1:0] faultAddr;
  logic faultAck = 1'b0;
  logic memValid, memWrite;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memBe;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata;

  always #10 clk = ~clk;  // 50 MHz

  mem_align_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .splitMode(splitMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .faultValid(faultValid), .faultAddr(faultAddr), .faultAck(faultAck),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata)
  );

  // Memory model: 16 words, read data one cycle later
  logic [7:0] shadow [0:127];
  logic [DATA_W-1:0] memArr [0:15];
  logic [DATA_W-1:0] rdQ = '0;
  assign memRdata = rdQ;

  always @(posedge clk) begin
    if (memValid) begin
      if (memWrite) begin
        for (int i = 0; i < 8; i++)
          if (memBe[i]) memArr[memAddr[6:3]][8*i +: 8] <= memWdata[8*i +: 8];
      end else begin
        rdQ <= memArr[memAddr[6:3]];
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expLoad(input int a, input int sz);
    logic [63:0] r = '0;
    for (int i = 0; i < (1 << sz); i++) r[8*i +: 8] = shadow[(a + i) & 127];
    return r;
  endfunction

  // Observation results of one request
  int nAcc, rspAt, faultAt, readyAtAccept;
  logic [ADDR_W-1:0] accAddr [0:3];
  logic [7:0] accBe [0:3];
  logic [63:0] rdata;
  logic [ADDR_W-1:0] fAddr;

  task automatic access(input bit wr, input int sz, input int a, input logic [63:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = 2'(sz);
    reqAddr = ADDR_W'(a); reqWdata = wd;
    nAcc = 0; rspAt = -1; faultAt = -1; rdata = '0; fAddr = '0;
    for (int c = 0; c < 4; c++) begin
      #2;
      if (c == 0) readyAtAccept = int'(reqReady);
      if (memValid) begin
        accAddr[nAcc] = memAddr; accBe[nAcc] = memBe; nAcc++;
      end
      if (rspValid && rspAt < 0) begin rspAt = c; rdata = rspRdata; end
      if (faultValid && faultAt < 0) begin faultAt = c; fAddr = faultAddr; end
      @(negedge clk);
      if (c == 0) reqValid = 1'b0;
    end
    if (wr && faultAt < 0)
      for (int i = 0; i < (1 << sz); i++) shadow[(a + i) & 127] = wd[8*i +: 8];
  endtask

  task automatic testReset;
    #2;
    chk("R11 reqReady", 64'(reqReady), 64'd1);
    chk("R11 memValid", 64'(memValid), 64'd0);
    chk("R11 rspValid", 64'(rspValid), 64'd0);
    chk("R11 faultValid", 64'(faultValid), 64'd0);
  endtask

  task automatic testAlignedLoads;
    splitMode = 1'b0;
    access(1'b0, 3, 'h10, '0);
    chk("R1 dword accesses", 64'(nAcc), 64'd1);
    chk("R1 dword rsp cycle", 64'(rspAt), 64'd1);
    chk("R2 dword data", rdata, expLoad('h10, 3));
    access(1'b0, 1, 'h22, '0);
    chk("R1 half ready", 64'(readyAtAccept), 64'd1);
    chk("R2 half data", rdata, expLoad('h22, 1));
    chk("R2 half be", 64'(accBe[0]), 64'h0C);
  endtask

  task automatic testAlignedStore;
    splitMode = 1'b0;
    access(1'b1, 2, 'h34, 64'h1122_3344_A1B2_C3D4);
    chk("R3 word be", 64'(accBe[0]), 64'hF0);
    chk("R3 word addr", 64'(accAddr[0]), 64'h30);
    chk("R1 store rsp", 64'(rspAt), 64'd1);
    access(1'b0, 3, 'h30, '0);
    chk("R3 readback", rdata, expLoad('h30, 3));
  endtask

  task automatic testByteAnyOffset;
    splitMode = 1'b0;
    access(1'b0, 0, 'h47, '0);
    chk("R10 byte no fault", 64'(faultAt), 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 byte data", rdata, expLoad('h47, 0));
  endtask

  task automatic testTrap;
    splitMode = 1'b0;
    access(1'b0, 2, 'h4D, '0);
    chk("R4 no access", 64'(nAcc), 64'd0);
    chk("R4 fault cycle", 64'(faultAt), 64'd1);
    chk("R4 fault addr", 64'(fAddr), 64'h4D);
    chk("R4 no rsp", 64'(rspAt), 64'hFFFF_FFFF_FFFF_FFFF);
    // R5: held, blocks new requests
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = 2'd3; reqAddr = 'h08;
    #2;
    chk("R5 fault held", 64'(faultValid), 64'd1);
    chk("R5 ready low", 64'(reqReady), 64'd0);
    chk("R5 no access", 64'(memValid), 64'd0);
    chk("R5 addr held", 64'(faultAddr), 64'h4D);
    @(negedge clk);
    reqValid = 1'b0; faultAck = 1'b1;
    #2;
    chk("R5 before ack edge", 64'(faultValid), 64'd1);
    @(negedge clk);
    faultAck = 1'b0;
    #2;
    chk("R5 cleared", 64'(faultValid), 64'd0);
    chk("R5 ready back", 64'(reqReady), 64'd1);
  endtask

  task automatic testSplitLoad;
    splitMode = 1'b1;
    access(1'b0, 3, 'h13, '0);
    chk("R6 two accesses", 64'(nAcc), 64'd2);
    chk("R6 first word", 64'(accAddr[0]), 64'h10);
    chk("R6 second word", 64'(accAddr[1]), 64'h18);
    chk("R6 rsp cycle", 64'(rspAt), 64'd2);
    chk("R7 merged data", rdata, expLoad('h13, 3));
    chk("R9 no fault split", 64'(faultAt), 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic testSplitStore;
    splitMode = 1'b1;
    access(1'b1, 2, 'h3E, 64'h0000_0000_CAFE_F00D);
    chk("R8 first be", 64'(accBe[0]), 64'hC0);
    chk("R8 second be", 64'(accBe[1]), 64'h03);
    access(1'b0, 3, 'h38, '0);
    chk("R8 low word", rdata, expLoad('h38, 3));
    access(1'b0, 3, 'h40, '0);
    chk("R8 high word", rdata, expLoad('h40, 3));
    access(1'b0, 2, 'h3E, '0);
    chk("R7 word across", rdata, 64'h0000_0000_CAFE_F00D);
  endtask

  task automatic testSplitInside;
    splitMode = 1'b1;
    access(1'b0, 1, 'h51, '0);
    chk("R9 one access", 64'(nAcc), 64'd1);
    chk("R9 rsp cycle", 64'(rspAt), 64'd1);
    chk("R9 data", rdata, expLoad('h51, 1));
    access(1'b0, 3, 'h28, '0);
    chk("R1 split aligned rsp", 64'(rspAt), 64'd1);
    chk("R1 split aligned count", 64'(nAcc), 64'd1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = 8'(i * 37 + 11);
    for (int w = 0; w < 16; w++)
      for (int b = 0; b < 8; b++) memArr[w][8*b +: 8] = shadow[w*8 + b];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAlignedLoads();
    testAlignedStore();
    testByteAnyOffset();
    testTrap();
    testSplitLoad();
    testSplitStore();
    testSplitInside();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule